// File: doc/BRIEF.md
# Watchdog Timer with Level or Pulse Reset Output

This block is a register-programmed watchdog. Software loads an 8-bit time value and arms the timer. The timer then counts down in units of seconds or minutes. Each unit is derived from a 1 ms tick by two prescalers inside the block. Writing the time value again reloads the counter, and this write is the keep-alive.

If the count runs out, the block sets a sticky timeout flag. It also drives an active-low reset output, provided the output driver is enabled. The output is either a held level or a single pulse. The pulse width is chosen from four coded lengths, each set by a parameter.

The timer runs only while the logical-device enable input and the software enable bit are both high. The timeout flag is cleared only by writing a one to it, so it outlives the system reset that the watchdog itself caused.

Top module: `wdg_pulse_reset`

## Requirements
- R1: After reset, every register reads 0 and `rst_out_n` is 1.
- R2: Register layout.
  - Address 0xF5 (control): bit 6 is the timeout flag, bit 5 is the enable, bit 4 selects pulse (1) or level (0) output, bit 3 selects minutes (1) or seconds (0), and bits 1:0 hold the pulse code. Bits 7 and 2 read 0.
  - Address 0xF0: bit 7 is the output-driver enable and all other bits read 0.
  - Address 0xF6: writes load the time value; reads return the current count.
  - Any other address reads 0.
- R3: A write to 0xF6 loads the written value into the count. It clears both prescalers and releases an asserted output.
- R4: The count holds, and the prescalers stay cleared, unless `ld_en` and the enable bit are both 1. Whenever the timer is not running, `rst_out_n` is 1 from the next cycle on.
- R5: While the timer runs, the count steps once every TICKS_PER_SEC ticks in seconds mode. In minutes mode it steps once every TICKS_PER_SEC*SECS_PER_MIN ticks.
- R6: A unit step that finds the count at 1 or 0 sets the count to 0, sets the timeout flag and marks the timer expired. An expired timer stops counting until it is reloaded or stopped.
- R7: An expired timer drives `rst_out_n` to 0 only while the output enable is 1. In level mode the output stays low until a reload, a cleared enable or a drop of `ld_en`.
- R8: In pulse mode, `rst_out_n` goes low on expiry for exactly PWn ticks, where n is the pulse code (code 0 → PW_CODE0_MS, up to code 3 → PW_CODE3_MS). It then returns to 1 and stays there until the next expiry.
- R9: Writing 1 to bit 6 of 0xF5 clears the timeout flag, and writing 0 to it has no effect. The flag survives reloads and stops. An expiry in the same cycle as a clear wins.
- R10: Writing the enable bit to 0 stops the count at its present value and releases the output. The timeout flag is left as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| ld_en | input | 1 | Logical-device enable from the configuration port |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address (write and read) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rst_out_n | output | 1 | Active-low watchdog reset output |

## Verification
The bench builds the block with four ticks per second and three seconds per minute. It uses pulse widths of 1, 2, 3 and 5 ticks. With these values a minutes-mode expiry takes twelve ticks, and every pulse code finishes within a few cycles, so the minute divider, the pulse lengths and the release after a pulse can all be measured exactly. A behavioural model runs beside the design and compares the output and the read data on every clock.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
    localparam logic [7:0] ADDR_OUTCFG = 8'hF0;
    localparam logic [7:0] ADDR_CTRL   = 8'hF5;
    localparam logic [7:0] ADDR_TIME   = 8'hF6;

    localparam int BIT_OE      = 7;
    localparam int BIT_STAT    = 6;
    localparam int BIT_EN      = 5;
    localparam int BIT_PULSE   = 4;
    localparam int BIT_MINUTES = 3;

    typedef struct packed {
        logic       oe;
        logic       stat;
        logic       en;
        logic       pulse;
        logic       minutes;
        logic [1:0] pw;
        logic [7:0] cnt;
        logic       fired;
    } wdg_state_t;
endpackage

// File: rtl/wdg_prescale.sv
`timescale 1ns/1ps
module wdg_prescale #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic use_min,
    output logic unit_tick
);
    localparam int MSW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int SCW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
    localparam logic [MSW-1:0] MS_LAST  = MSW'(TICKS_PER_SEC - 1);
    localparam logic [SCW-1:0] SEC_LAST = SCW'(SECS_PER_MIN - 1);

    typedef struct packed {
        logic [MSW-1:0] ms;
        logic [SCW-1:0] sec;
    } psc_t;

    psc_t psc_d, psc_q;
    logic sec_tick, min_tick;

    always_comb begin
        psc_d    = psc_q;
        sec_tick = 1'b0;
        min_tick = 1'b0;
        if (clr) begin
            psc_d = '0;
        end else if (tick) begin
            if (psc_q.ms == MS_LAST) begin
                psc_d.ms = '0;
                sec_tick = 1'b1;
                if (psc_q.sec == SEC_LAST) begin
                    psc_d.sec = '0;
                    min_tick  = 1'b1;
                end else begin
                    psc_d.sec = psc_q.sec + 1'b1;
                end
            end else begin
                psc_d.ms = psc_q.ms + 1'b1;
            end
        end
        unit_tick = use_min ? min_tick : sec_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q.ms <= MS_LAST); // R5
    AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q.sec <= SEC_LAST); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (psc_q.ms == '0)); // R4
endmodule

// File: rtl/wdg_pulse.sv
`timescale 1ns/1ps
module wdg_pulse #(
    parameter int PW_CODE0_MS = 1,
    parameter int PW_CODE1_MS = 25,
    parameter int PW_CODE2_MS = 125,
    parameter int PW_CODE3_MS = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    input  logic       clr,
    input  logic       tick,
    output logic       busy
);
    localparam int CW = $clog2(PW_CODE3_MS + 1);

    logic [CW-1:0] left_d, left_q, width;

    always_comb begin
        case (code)
            2'd0:    width = CW'(PW_CODE0_MS);
            2'd1:    width = CW'(PW_CODE1_MS);
            2'd2:    width = CW'(PW_CODE2_MS);
            default: width = CW'(PW_CODE3_MS);
        endcase
        left_d = left_q;
        if (load)                        left_d = width;
        else if (clr)                    left_d = '0;
        else if (tick && left_q != '0)   left_d = left_q - 1'b1;
        busy = (left_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(PW_CODE3_MS)); // R8
    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && width != '0) |=> busy); // R8
endmodule

// File: rtl/wdg_pulse_reset.sv
`timescale 1ns/1ps
module wdg_pulse_reset
    import wdg_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60,
    parameter int PW_CODE0_MS   = 1,
    parameter int PW_CODE1_MS   = 25,
    parameter int PW_CODE2_MS   = 125,
    parameter int PW_CODE3_MS   = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic       tick_ms,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_out_n
);
    wdg_state_t st_d, st_q;
    logic run, time_wr, ctrl_wr, ocfg_wr;
    logic unit_tick, tmo, pulse_busy, stop_clr;

    wdg_prescale #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .SECS_PER_MIN (SECS_PER_MIN)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stop_clr),
        .tick     (tick_ms),
        .use_min  (st_q.minutes),
        .unit_tick(unit_tick)
    );

    wdg_pulse #(
        .PW_CODE0_MS(PW_CODE0_MS),
        .PW_CODE1_MS(PW_CODE1_MS),
        .PW_CODE2_MS(PW_CODE2_MS),
        .PW_CODE3_MS(PW_CODE3_MS)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmo),
        .code (st_q.pw),
        .clr  (stop_clr),
        .tick (tick_ms),
        .busy (pulse_busy)
    );

    always_comb begin
        time_wr  = wr_en && (addr == ADDR_TIME);
        ctrl_wr  = wr_en && (addr == ADDR_CTRL);
        ocfg_wr  = wr_en && (addr == ADDR_OUTCFG);
        run      = ld_en && st_q.en;
        stop_clr = !run || time_wr;
        tmo      = run && unit_tick && !st_q.fired && !time_wr && (st_q.cnt <= 8'd1);

        st_d = st_q;
        if (time_wr)
            st_d.cnt = wdata;
        else if (run && unit_tick && !st_q.fired)
            st_d.cnt = (st_q.cnt <= 8'd1) ? 8'd0 : st_q.cnt - 8'd1;

        if (stop_clr)  st_d.fired = 1'b0;
        else if (tmo)  st_d.fired = 1'b1;

        if (tmo)                              st_d.stat = 1'b1;
        else if (ctrl_wr && wdata[BIT_STAT])  st_d.stat = 1'b0;

        if (ctrl_wr) begin
            st_d.en      = wdata[BIT_EN];
            st_d.pulse   = wdata[BIT_PULSE];
            st_d.minutes = wdata[BIT_MINUTES];
            st_d.pw      = wdata[1:0];
        end
        if (ocfg_wr) st_d.oe = wdata[BIT_OE];

        case (addr)
            ADDR_OUTCFG: rdata = {st_q.oe, 7'b0};
            ADDR_CTRL:   rdata = {1'b0, st_q.stat, st_q.en, st_q.pulse,
                                  st_q.minutes, 1'b0, st_q.pw};
            ADDR_TIME:   rdata = st_q.cnt;
            default:     rdata = 8'h00;
        endcase

        rst_out_n = !(st_q.fired && st_q.oe && (st_q.pulse ? pulse_busy : 1'b1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> (st_q.cnt == $past(wdata))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr) |=> $stable(st_q.cnt)); // R4
    AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> rst_out_n); // R10
    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fired) |-> st_q.stat); // R6
    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> st_q.oe); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat && !(ctrl_wr && wdata[BIT_STAT])) |=> st_q.stat); // R9
endmodule

// File: tb/tb_wdg_pulse_reset.sv
`timescale 1ns/1ps
module tb_wdg_pulse_reset;
    localparam int TPS = 4;
    localparam int SPM = 3;
    localparam int PW0 = 1, PW1 = 2, PW2 = 3, PW3 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0, tick_ms = 1'b0, wr_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic rst_out_n;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdg_pulse_reset #(
        .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
        .PW_CODE0_MS(PW0), .PW_CODE1_MS(PW1), .PW_CODE2_MS(PW2), .PW_CODE3_MS(PW3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .tick_ms(tick_ms),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out_n(rst_out_n)
    );

    // behavioural reference model
    int m_ms, m_sec, m_cnt, m_pc;
    bit m_en, m_pulse, m_min, m_oe, m_stat, m_fired;
    int m_pw;

    function automatic int pw_of(input int c);
        case (c)
            0: return PW0;
            1: return PW1;
            2: return PW2;
            default: return PW3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ms = 0; m_sec = 0; m_cnt = 0; m_pc = 0; m_pw = 0;
            m_en = 0; m_pulse = 0; m_min = 0; m_oe = 0; m_stat = 0; m_fired = 0;
        end else begin
            bit run, twr, cwr, utick, tmo;
            run = ld_en && m_en;
            twr = wr_en && addr == 8'hF6;
            cwr = wr_en && addr == 8'hF5;
            utick = 0;
            if (!run || twr) begin
                m_ms = 0; m_sec = 0;
            end else if (tick_ms) begin
                m_ms++;
                if (m_ms == TPS) begin
                    m_ms = 0;
                    if (!m_min) utick = 1;
                    m_sec++;
                    if (m_sec == SPM) begin
                        m_sec = 0;
                        if (m_min) utick = 1;
                    end
                end
            end
            tmo = run && utick && !m_fired && m_cnt <= 1;
            if (tmo) m_pc = pw_of(m_pw);
            else if (!run || twr) m_pc = 0;
            else if (tick_ms && m_pc > 0) m_pc--;
            if (twr) m_cnt = wdata;
            else if (run && utick && !m_fired) m_cnt = (m_cnt <= 1) ? 0 : m_cnt - 1;
            if (twr || !run) m_fired = 0;
            else if (tmo) m_fired = 1;
            if (tmo) m_stat = 1;
            else if (cwr && wdata[6]) m_stat = 0;
            if (cwr) begin
                m_en = wdata[5]; m_pulse = wdata[4]; m_min = wdata[3]; m_pw = wdata[1:0];
            end
            if (wr_en && addr == 8'hF0) m_oe = wdata[7];
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'hF0: return {m_oe, 7'b0};
            8'hF5: return {1'b0, m_stat, m_en, m_pulse, m_min, 1'b0, 2'(m_pw)};
            8'hF6: return 8'(m_cnt);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R7 model rst_out_n", int'(rst_out_n),
                int'(!(m_fired && m_oe && (m_pulse ? (m_pc > 0) : 1'b1))));
            chk("R2 model rdata", int'(rdata), int'(exp_rd(addr)));
        end
    end

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0; tick_ms = tk;
        end
        @(negedge clk);
        tick_ms = 0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; tick_ms = 0;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic peek(input logic [7:0] a, output int v);
        @(negedge clk);
        wr_en = 0; tick_ms = 0; addr = a;
        @(posedge clk);
        #1 v = int'(rdata);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0; tick_ms = 1;
            @(posedge clk);
            #1 if (!rst_out_n) lows++;
        end
        @(negedge clk);
        tick_ms = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v, lows;
        repeat (3) @(negedge clk);
        rst_n = 1;
        peek(8'hF5, v); chk("R1 ctrl after reset", v, 0);
        peek(8'hF0, v); chk("R1 outcfg after reset", v, 0);
        peek(8'hF6, v); chk("R1 count after reset", v, 0);
        chk("R1 output after reset", int'(rst_out_n), 1);
        peek(8'h12, v); chk("R2 unmapped reads 0", v, 0);

        wreg(8'hF0, 8'hFF);
        peek(8'hF0, v); chk("R2 outcfg only bit 7", v, 8'h80);
        wreg(8'hF5, 8'hA4);
        peek(8'hF5, v); chk("R2 ctrl bits 7 and 2 read 0", v, 8'h20);

        ld_en = 0;
        wreg(8'hF6, 8'd3);
        idle(20, 1);
        peek(8'hF6, v); chk("R4 hold without ld_en", v, 3);

        ld_en = 1;
        idle(4, 1);
        peek(8'hF6, v); chk("R5 seconds step", v, 2);
        idle(8, 1);
        peek(8'hF5, v); chk("R6 flag set on expiry", v, 8'h60);
        chk("R7 level asserted", int'(rst_out_n), 0);
        idle(10, 1);
        chk("R7 level held", int'(rst_out_n), 0);
        peek(8'hF6, v); chk("R6 count stopped at 0", v, 0);

        wreg(8'hF5, 8'h20);
        peek(8'hF5, v); chk("R9 write 0 keeps flag", v, 8'h60);
        wreg(8'hF6, 8'd2);
        chk("R3 reload releases output", int'(rst_out_n), 1);
        peek(8'hF6, v); chk("R3 reload value", v, 2);
        peek(8'hF5, v); chk("R9 flag survives reload", v, 8'h60);
        wreg(8'hF5, 8'h60);
        peek(8'hF5, v); chk("R9 write 1 clears flag", v, 8'h20);

        idle(3, 1);
        wreg(8'hF6, 8'd2);
        idle(3, 1);
        peek(8'hF6, v); chk("R3 prescaler cleared by reload", v, 2);
        idle(1, 1);
        peek(8'hF6, v); chk("R3 step after full second", v, 1);
        idle(4, 1);
        chk("R6 expiry from count 1", int'(rst_out_n), 0);
        wreg(8'hF6, 8'd5);
        wreg(8'hF5, 8'h00);
        chk("R10 disable releases output", int'(rst_out_n), 1);
        idle(20, 1);
        peek(8'hF6, v); chk("R10 count held when disabled", v, 5);
        peek(8'hF5, v); chk("R10 flag untouched by stop", v, 8'h40);

        wreg(8'hF0, 8'h00);
        wreg(8'hF5, 8'h60);
        wreg(8'hF6, 8'd1);
        idle(4, 1);
        peek(8'hF5, v); chk("R6 flag set with driver off", v, 8'h60);
        chk("R7 no output without driver enable", int'(rst_out_n), 1);
        wreg(8'hF0, 8'h80);
        chk("R7 driver enable exposes level", int'(rst_out_n), 0);
        ld_en = 0;
        idle(1, 0);
        chk("R4 ld_en drop releases", int'(rst_out_n), 1);

        ld_en = 1;
        wreg(8'hF5, 8'h72);
        wreg(8'hF6, 8'd1);
        idle(3, 1);
        count_low(12, lows);
        chk("R8 pulse code 2 width", lows, PW2);
        chk("R8 released after pulse", int'(rst_out_n), 1);
        peek(8'hF5, v); chk("R8 flag after pulse expiry", v, 8'h72);

        wreg(8'hF5, 8'h30);
        wreg(8'hF6, 8'd1);
        idle(3, 1);
        count_low(8, lows);
        chk("R8 pulse code 0 width", lows, PW0);

        wreg(8'hF5, 8'h33);
        wreg(8'hF6, 8'd1);
        idle(3, 1);
        count_low(10, lows);
        chk("R8 pulse code 3 width", lows, PW3);

        wreg(8'hF5, 8'h68);
        wreg(8'hF6, 8'd1);
        idle(TPS * SPM - 1, 1);
        peek(8'hF6, v); chk("R5 minutes not yet", v, 1);
        idle(1, 1);
        peek(8'hF6, v); chk("R5 minutes step", v, 0);
        chk("R5 minutes expiry output", int'(rst_out_n), 0);

        idle(4, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule